// File: doc/BRIEF.md
# Flash Toggle-Bit Completion Poller

This block sits on the host side of a parallel flash and decides whether an embedded program or erase has finished, using the toggle-bit method. After the host has issued the operation, it pulses `start` with the target address. The poller then reads the status byte through a simple request/done memory port. It compares the toggle bit across consecutive reads and watches the exceeded-time bit. It reports the outcome with a one-cycle `done` pulse plus held `pass` and `fail` flags.

A single pair of reads cannot settle a busy device. If the toggle bit is still moving and the error bit is low, the poller keeps reading in pairs. If the error bit is high, it reads one more pair, because toggling may have stopped just as the error bit rose. A toggle in that re-check pair is a failure. The poller then writes the reset command to the device and raises `fail` only after that write completes. A pair limit gives up with a timeout failure when the error bit never rises. An `abort` input abandons a poll, and the next poll starts over from a fresh pair of reads.

Top module: `tbpoll_ctrl`

## Requirements
- R1: After reset, `mem_req`, `done`, `pass`, `fail` and `timeout` are all 0.
- R2: A `start` seen in idle launches a read (`mem_we`=0) to `start_addr` in the next cycle. Every access of that poll uses the same address. `start` is ignored while a poll is running.
- R3: In a read pair, the toggle bit is bit 6 of the status byte. If bit 6 of the second read equals bit 6 of the first, the poll passes with no further access. `done` and `pass` rise one cycle after the `mem_done` of that second read.
- R4: If bit 6 differs within a pair and bit 5 of the second read is 0, a new pair of reads follows at once.
- R5: If bit 6 differs and bit 5 of the second read is 1, exactly one re-check pair is read. If bit 6 matches within that pair, the poll passes.
- R6: If the re-check pair still toggles, one write of data 0xF0 to the target address follows. `fail` and `done` rise one cycle after that write's `mem_done`.
- R7: When MAX_PAIRS consecutive pairs toggle with bit 5 low, the poller performs the same 0xF0 write and then reports `fail` together with `timeout`.
- R8: `done` lasts exactly one cycle. `pass`, `fail` and `timeout` hold until the next accepted `start`, which clears them. `pass` and `fail` are never both 1.
- R9: `abort` returns the poller to idle: `mem_req` is 0 in the next cycle and no `done` follows. The next poll begins again with two fresh reads.
- R10: Once raised, `mem_req`, `mem_we` and `mem_addr` stay stable until `mem_done` or `abort`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a poll (accepted in idle) |
| start_addr | input | AW | Target address of the operation being polled |
| abort | input | 1 | Abandon the poll and return to idle |
| mem_req | output | 1 | Memory access request, held until done |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Access address |
| mem_wdata | output | 8 | Write data (reset command) |
| mem_rdata | input | 8 | Status byte returned by a read |
| mem_done | input | 1 | One-cycle completion of the current access |
| done | output | 1 | One-cycle pulse when a poll concludes |
| pass | output | 1 | Operation completed successfully |
| fail | output | 1 | Operation failed; reset command already written |
| timeout | output | 1 | Failure came from the pair limit |

## Verification
Each result is due exactly one cycle after the `mem_done` of the access that decides it. The first request appears one cycle after `start` is sampled, and `mem_req` drops one cycle after `abort`. The bench samples on the falling edge and records the cycle of the last `mem_done`. It then requires `done` in the next sample and checks that `done` is gone one sample later while the flags hold. A bench-side device model counts the reads and writes of each poll. Those counts are compared against an arithmetic walk of the pair rules, swept over every combination of busy length and error-bit arrival in a small configuration.

// File: rtl/tbpoll_pkg.sv
package tbpoll_pkg;
  localparam int DATA_W     = 8;
  localparam int TOGGLE_POS = 6;
  localparam int ERROR_POS  = 5;
  localparam logic [DATA_W-1:0] RESET_CMD = 8'hF0;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_A,
    ST_RD_B,
    ST_CHK_A,
    ST_CHK_B,
    ST_RST_WR
  } poll_state_t;
endpackage

// File: rtl/tbpoll_bus_port.sv
module tbpoll_bus_port #(
  parameter int AW = 24
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           kill,
  input  logic                           launch,
  input  logic                           launch_we,
  input  logic [AW-1:0]                  launch_addr,
  input  logic [tbpoll_pkg::DATA_W-1:0]  launch_wdata,
  input  logic                           mem_done,
  output logic                           mem_req,
  output logic                           mem_we,
  output logic [AW-1:0]                  mem_addr,
  output logic [tbpoll_pkg::DATA_W-1:0]  mem_wdata
);
  always_ff @(posedge clk) begin
    if (rst || kill) begin
      mem_req <= 1'b0;
    end else if (launch) begin
      mem_req <= 1'b1;
    end else if (mem_done) begin
      mem_req <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else if (launch && !kill) begin
      mem_we    <= launch_we;
      mem_addr  <= launch_addr;
      mem_wdata <= launch_wdata;
    end
  end
endmodule

// File: rtl/tbpoll_toggle_eval.sv
module tbpoll_toggle_eval (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic capture,
  input  logic tog_bit,
  input  logic err_bit,
  output logic toggled,
  output logic err_high
);
  logic first_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      first_q <= 1'b0;
    end else if (capture) begin
      first_q <= tog_bit;
    end
  end

  always_comb begin
    toggled  = tog_bit ^ first_q;
    err_high = err_bit;
  end
endmodule

// File: rtl/tbpoll_pair_ctr.sv
module tbpoll_pair_ctr #(
  parameter int MAX_PAIRS = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic inc,
  output logic at_last
);
  localparam int CW = (MAX_PAIRS > 1) ? $clog2(MAX_PAIRS + 1) : 1;
  localparam logic [CW-1:0] LAST = CW'(MAX_PAIRS - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q <= '0;
    end else if (inc && cnt_q != LAST) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign at_last = (cnt_q == LAST);
endmodule

// File: rtl/tbpoll_seq.sv
module tbpoll_seq
  import tbpoll_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [AW-1:0]     start_addr,
  input  logic              abort,
  input  logic              mem_done,
  input  logic              toggled,
  input  logic              err_high,
  input  logic              at_last,
  output logic              launch,
  output logic              launch_we,
  output logic [AW-1:0]     launch_addr,
  output logic [DATA_W-1:0] launch_wdata,
  output logic              capture,
  output logic              clear_eval,
  output logic              pair_inc,
  output logic              pair_clr,
  output logic              done,
  output logic              pass,
  output logic              fail,
  output logic              timeout
);
  poll_state_t st_q, st_d;
  logic [AW-1:0] tgt_q;
  logic          to_pend_q;
  logic          fin_pass, fin_fail, set_to, accept;

  always_comb begin
    st_d         = st_q;
    launch       = 1'b0;
    launch_we    = 1'b0;
    launch_addr  = tgt_q;
    launch_wdata = '0;
    capture      = 1'b0;
    pair_inc     = 1'b0;
    pair_clr     = 1'b0;
    fin_pass     = 1'b0;
    fin_fail     = 1'b0;
    set_to       = 1'b0;
    accept       = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          accept      = 1'b1;
          launch      = 1'b1;
          launch_addr = start_addr;
          pair_clr    = 1'b1;
          st_d        = ST_RD_A;
        end
      end
      ST_RD_A: begin
        if (mem_done) begin
          capture = 1'b1;
          launch  = 1'b1;
          st_d    = ST_RD_B;
        end
      end
      ST_RD_B: begin
        if (mem_done) begin
          if (!toggled) begin
            fin_pass = 1'b1;
            st_d     = ST_IDLE;
          end else if (err_high) begin
            launch = 1'b1;
            st_d   = ST_CHK_A;
          end else if (at_last) begin
            launch       = 1'b1;
            launch_we    = 1'b1;
            launch_wdata = RESET_CMD;
            set_to       = 1'b1;
            st_d         = ST_RST_WR;
          end else begin
            pair_inc = 1'b1;
            launch   = 1'b1;
            st_d     = ST_RD_A;
          end
        end
      end
      ST_CHK_A: begin
        if (mem_done) begin
          capture = 1'b1;
          launch  = 1'b1;
          st_d    = ST_CHK_B;
        end
      end
      ST_CHK_B: begin
        if (mem_done) begin
          if (!toggled) begin
            fin_pass = 1'b1;
            st_d     = ST_IDLE;
          end else begin
            launch       = 1'b1;
            launch_we    = 1'b1;
            launch_wdata = RESET_CMD;
            st_d         = ST_RST_WR;
          end
        end
      end
      ST_RST_WR: begin
        if (mem_done) begin
          fin_fail = 1'b1;
          st_d     = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
    if (abort) begin
      st_d     = ST_IDLE;
      launch   = 1'b0;
      capture  = 1'b0;
      pair_inc = 1'b0;
      pair_clr = 1'b1;
      fin_pass = 1'b0;
      fin_fail = 1'b0;
      set_to   = 1'b0;
      accept   = 1'b0;
    end
  end

  assign clear_eval = abort || accept;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      tgt_q     <= '0;
      to_pend_q <= 1'b0;
      done      <= 1'b0;
      pass      <= 1'b0;
      fail      <= 1'b0;
      timeout   <= 1'b0;
    end else begin
      st_q <= st_d;
      done <= fin_pass || fin_fail;
      if (accept) begin
        tgt_q   <= start_addr;
        pass    <= 1'b0;
        fail    <= 1'b0;
        timeout <= 1'b0;
      end
      if (accept || abort) begin
        to_pend_q <= 1'b0;
      end else if (set_to) begin
        to_pend_q <= 1'b1;
      end
      if (fin_pass) begin
        pass <= 1'b1;
      end
      if (fin_fail) begin
        fail    <= 1'b1;
        timeout <= to_pend_q;
      end
    end
  end
endmodule

// File: rtl/tbpoll_ctrl.sv
module tbpoll_ctrl
  import tbpoll_pkg::*;
#(
  parameter int AW        = 24,
  parameter int MAX_PAIRS = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [AW-1:0]     start_addr,
  input  logic              abort,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_done,
  output logic              done,
  output logic              pass,
  output logic              fail,
  output logic              timeout
);
  logic              launch, launch_we, capture, clear_eval;
  logic              pair_inc, pair_clr, at_last, toggled, err_high;
  logic [AW-1:0]     launch_addr;
  logic [DATA_W-1:0] launch_wdata;
  logic              unused_rdata;

  assign unused_rdata = ^mem_rdata;

  tbpoll_seq #(.AW(AW)) u_seq (
    .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
    .abort(abort), .mem_done(mem_done), .toggled(toggled),
    .err_high(err_high), .at_last(at_last), .launch(launch),
    .launch_we(launch_we), .launch_addr(launch_addr),
    .launch_wdata(launch_wdata), .capture(capture),
    .clear_eval(clear_eval), .pair_inc(pair_inc), .pair_clr(pair_clr),
    .done(done), .pass(pass), .fail(fail), .timeout(timeout)
  );

  tbpoll_toggle_eval u_eval (
    .clk(clk), .rst(rst), .clear(clear_eval), .capture(capture),
    .tog_bit(mem_rdata[TOGGLE_POS]), .err_bit(mem_rdata[ERROR_POS]),
    .toggled(toggled), .err_high(err_high)
  );

  tbpoll_pair_ctr #(.MAX_PAIRS(MAX_PAIRS)) u_pairs (
    .clk(clk), .rst(rst), .clear(pair_clr), .inc(pair_inc),
    .at_last(at_last)
  );

  tbpoll_bus_port #(.AW(AW)) u_bus (
    .clk(clk), .rst(rst), .kill(abort), .launch(launch),
    .launch_we(launch_we), .launch_addr(launch_addr),
    .launch_wdata(launch_wdata), .mem_done(mem_done),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata)
  );
endmodule

// File: rtl/tbpoll_chk.sv
module tbpoll_chk #(
  parameter int AW = 24
) (
  input logic          clk,
  input logic          rst,
  input logic          abort,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [7:0]    mem_wdata,
  input logic          mem_done,
  input logic          done,
  input logic          pass,
  input logic          fail,
  input logic          timeout
);
  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_done && !abort) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8
  verdict_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(pass && fail));

  // R6
  fail_after_write_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(fail) |-> $past(mem_done && mem_we && mem_req));

  // R6
  write_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> (mem_wdata == 8'hF0));

  // R7
  timeout_fail_chk: assert property (@(posedge clk) disable iff (rst)
    timeout |-> fail);

  // R9
  abort_idle_chk: assert property (@(posedge clk) disable iff (rst)
    abort |=> (!mem_req && !done));
endmodule

bind tbpoll_ctrl tbpoll_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .abort(abort), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_done(mem_done),
  .done(done), .pass(pass), .fail(fail), .timeout(timeout)
);

// File: tb/sim_tbpoll_ctrl.sv
module sim_tbpoll_ctrl;
  localparam int AW   = 8;
  localparam int MAXP = 4;
  localparam int LAT  = 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          abort = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic          mem_req, mem_we, done, pass, fail, timeout;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_wdata;
  logic [7:0]    mem_rdata = 8'h00;
  logic          mem_done = 1'b0;

  int nchk = 0;
  int nfail = 0;
  int wd = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  tbpoll_ctrl #(.AW(AW), .MAX_PAIRS(MAXP)) u0 (
    .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
    .abort(abort), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_done(mem_done), .done(done), .pass(pass), .fail(fail),
    .timeout(timeout)
  );

  // device model: toggles bit 6 for the first dev_b reads, bit 5 set from read dev_f on
  int dev_b = 0;
  int dev_f = 99;
  bit dev_clr = 0;
  int ridx = 0;
  int wcnt = 0;
  int lat_cnt = 0;
  logic [7:0]    last_wdata = 8'h00;
  logic [AW-1:0] last_waddr = '0;

  function automatic logic [7:0] status_byte(int i, int b, int f);
    int m;
    logic [7:0] s;
    m = (i < b) ? i : b;
    s = 8'h08;
    s[6] = m[0];
    s[5] = (i >= f);
    return s;
  endfunction

  always @(posedge clk) begin
    if (dev_clr) begin
      ridx <= 0;
      wcnt <= 0;
    end
    if (rst) begin
      mem_done <= 1'b0;
      lat_cnt  <= 0;
    end else if (mem_done) begin
      mem_done <= 1'b0;
      lat_cnt  <= 0;
    end else if (!mem_req) begin
      lat_cnt <= 0;
    end else if (lat_cnt == LAT) begin
      mem_done <= 1'b1;
      lat_cnt  <= 0;
      if (mem_we) begin
        wcnt       <= wcnt + 1;
        last_wdata <= mem_wdata;
        last_waddr <= mem_addr;
      end else begin
        mem_rdata <= status_byte(ridx, dev_b, dev_f);
        ridx      <= ridx + 1;
      end
    end else begin
      lat_cnt <= lat_cnt + 1;
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // arithmetic walk of the pair rules
  task automatic ref_poll(int b, int f, output bit p, output bit fl,
                          output bit t, output int nr, output int nw);
    int i;
    int pairs;
    bit fin;
    i = 0; pairs = 0; fin = 0;
    p = 0; fl = 0; t = 0; nw = 0;
    while (!fin) begin
      int sec;
      sec = i + 1;
      i += 2;
      if (!(sec <= b)) begin
        p = 1; fin = 1;
      end else if (sec >= f) begin
        int sec2;
        sec2 = i + 1;
        i += 2;
        if (sec2 <= b) begin fl = 1; nw = 1; end
        else p = 1;
        fin = 1;
      end else begin
        pairs++;
        if (pairs == MAXP) begin
          fl = 1; t = 1; nw = 1; fin = 1;
        end
      end
    end
    nr = i;
  endtask

  task automatic dev_setup(int b, int f);
    dev_b = b;
    dev_f = f;
    dev_clr = 1;
    @(negedge clk);
    dev_clr = 0;
    @(negedge clk);
  endtask

  task automatic run_case(int b, int f, logic [AW-1:0] addr);
    bit ep, ef, et, got;
    int enr, enw, lmd, lat, bad, dn;
    dev_setup(b, f);
    start_addr = addr;
    start = 1;
    @(negedge clk);
    start = 0;
    chk(pass == 0 && fail == 0 && timeout == 0, "R8", "flags cleared by start",
        {pass, fail, timeout}, 0);
    chk(mem_req && !mem_we && mem_addr == addr, "R2", "first read launched",
        {mem_req, mem_we, (mem_addr == addr)}, 3'b101);
    got = 0; lmd = -10; lat = 0; bad = 0; dn = 0;
    for (int k = 0; k < 600 && !got; k++) begin
      @(negedge clk);
      if (mem_done) lmd = k;
      if (mem_req && mem_addr != addr) bad++;
      if (done) begin got = 1; lat = k - lmd; dn++; end
    end
    ref_poll(b, f, ep, ef, et, enr, enw);
    chk(got, "R3", "done seen", got, 1);
    chk(lat == 1, "R3", "done one cycle after last mem_done", lat, 1);
    chk(pass == ep, "R3,R5", "pass", pass, ep);
    chk(fail == ef, "R6", "fail", fail, ef);
    chk(timeout == et, "R7", "timeout", timeout, et);
    chk(ridx == enr, "R4", "read count", ridx, enr);
    chk(wcnt == enw, "R6", "reset write count", wcnt, enw);
    if (enw != 0) begin
      chk(last_wdata == 8'hF0, "R6", "reset command data", last_wdata, 8'hF0);
      chk(last_waddr == addr, "R6", "reset command address", last_waddr, addr);
    end
    chk(bad == 0, "R2", "address mismatches", bad, 0);
    @(negedge clk);
    chk(!done, "R8", "done one cycle", done, 0);
    chk(pass == ep && fail == ef, "R8", "flags held", {pass, fail}, {ep, ef});
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      if (done) dn++;
    end
    chk(dn == 1 && !mem_req, "R3", "no further activity", dn, 1);
  endtask

  always @(negedge clk) begin
    wd++;
    if (wd > 150000 && !finished) begin
      finished = 1;
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual %0d expected below %0d", wd, 150000);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(!mem_req && !done && !pass && !fail && !timeout, "R1", "reset state",
        {mem_req, done, pass, fail, timeout}, 0);
    rst = 0;
    @(negedge clk);
    chk(!mem_req && !done && !pass && !fail && !timeout, "R1", "idle after reset",
        {mem_req, done, pass, fail, timeout}, 0);

    for (int b = 0; b < 10; b++) begin
      for (int fi = 0; fi < 12; fi++) begin
        int f;
        f = (fi == 11) ? 99 : fi;
        run_case(b, f, AW'(b * 16 + fi));
      end
    end

    // R9: abort mid-poll, then a fresh poll
    begin
      int dn;
      dev_setup(100, 99);
      start_addr = 8'h5A;
      start = 1;
      @(negedge clk);
      start = 0;
      for (int k = 0; k < 50 && ridx < 1; k++) @(negedge clk);
      abort = 1;
      @(negedge clk);
      abort = 0;
      chk(!mem_req && !done, "R9", "abort drops request", {mem_req, done}, 0);
      dn = 0;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        if (done || mem_req) dn++;
      end
      chk(dn == 0, "R9", "no activity after abort", dn, 0);
      chk(!pass && !fail, "R9", "no verdict after abort", {pass, fail}, 0);
      run_case(0, 99, 8'h33);
      chk(ridx == 2, "R9", "restart uses two fresh reads", ridx, 2);
    end

    // R2: start during a poll is ignored
    begin
      dev_setup(6, 99);
      start_addr = 8'h11;
      start = 1;
      @(negedge clk);
      start_addr = 8'h77;
      @(negedge clk);
      start = 0;
      for (int k = 0; k < 200 && !done; k++) @(negedge clk);
      chk(pass && ridx == 8, "R2", "start ignored while busy", ridx, 8);
      repeat (3) @(negedge clk);
    end

    finished = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule